// File: doc/BRIEF.md
# SPI Receive Word Match Detector

This block sits beside the receive path of an SPI peripheral and watches every data word that the shifter delivers. It compares each word with two programmable 32-bit reference values, `cmp_a` and `cmp_b`, under a rule chosen by a 3-bit mode field. When the rule is met, it raises a sticky match flag that software can use, for example, to wake up on a known header or to trigger a receive stage. Software clears the flag with a one-cycle write-one-to-clear pulse.

The rules fall into four groups. The first group checks only the opening word of a frame. The second group checks every word. The third group looks for a two-word sequence, either at the start of the frame or anywhere in it. The fourth group compares a word with `cmp_a` through a bit mask held in `cmp_b`. A frame begins with a `sof` pulse. The detector keeps three pieces of state: whether the next accepted word opens the frame, whether it is the second word, and whether the previous word equalled `cmp_a`.

Top module: `spi_rx_match`

## Requirements
- R1: With `mode` = 3'b000, no received word sets `match_flag`.
- R2: The reserved code `mode` = 3'b001 behaves like 3'b000: no received word sets `match_flag`.
- R3: With `mode` = 3'b010, `match_flag` is 1 on the cycle after a valid word that opens a frame and equals `cmp_a` or `cmp_b`. Later words in that frame do not set it.
- R4: With `mode` = 3'b011, `match_flag` is 1 on the cycle after any valid word that equals `cmp_a` or `cmp_b`.
- R5: With `mode` = 3'b100, the flag sets on the cycle after the second word of a frame when that word equals `cmp_b` and the frame's first word equalled `cmp_a`.
- R6: With `mode` = 3'b101, the flag sets on the cycle after a valid word equal to `cmp_b` whose immediately preceding valid word in the same frame equalled `cmp_a`. A `sof`, or an intervening word that is not equal to `cmp_a`, breaks the pair.
- R7: With `mode` = 3'b110, the flag sets on the cycle after a frame's first word w for which (w & `cmp_b`) == (`cmp_a` & `cmp_b`).
- R8: With `mode` = 3'b111, the flag sets on the cycle after any valid word w for which (w & `cmp_b`) == (`cmp_a` & `cmp_b`).
- R9: `match_flag` stays set until a cycle with `flag_clr` = 1, after which it reads 0. If a new match and `flag_clr` arrive in the same cycle, the flag stays 1.
- R10: After reset, `match_flag` is 0, and the first valid word counts as the opening word of a frame.
- R11: A word with `rx_valid` and `sof` both high in the same cycle is the opening word of a new frame. Any pending first-word or pair state from the old frame is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sof | input | 1 | Start-of-frame pulse |
| rx_valid | input | 1 | Received word strobe |
| rx_word | input | W | Received data word |
| cmp_a | input | W | First match reference |
| cmp_b | input | W | Second match reference, or the mask in the masked modes |
| mode | input | 3 | Match rule select |
| flag_clr | input | 1 | Write-one-to-clear pulse for the flag |
| match_flag | output | 1 | Sticky match flag |

## Verification
Random frames draw their words from a small set: `cmp_a`, `cmp_b`, words that match under the mask, and free random values. This mix makes hits frequent, and every mode is measured against a frame-position model kept in the bench. Directed sequences target the cases that tell modes apart. A pair `cmp_a`,`cmp_b` that starts the frame sets the flag under both pair rules. The same pair shifted one word later sets it only under 3'b101, and a pair broken by `sof` sets it under neither. A reserved-code word equal to `cmp_a` must leave the flag clear. A clear pulse that meets a fresh match must lose to it.

// File: rtl/spi_rx_match.sv
module spi_rx_match #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sof,
  input  logic         rx_valid,
  input  logic [W-1:0] rx_word,
  input  logic [W-1:0] cmp_a,
  input  logic [W-1:0] cmp_b,
  input  logic [2:0]   mode,
  input  logic         flag_clr,
  output logic         match_flag
);

  logic first_q, second_q, prev_a_q;
  logic hit;

  wire eq_a      = (rx_word == cmp_a);
  wire eq_b      = (rx_word == cmp_b);
  wire masked_eq = ((rx_word & cmp_b) == (cmp_a & cmp_b));
  wire is_first  = sof | first_q;
  wire is_second = second_q & ~sof;
  wire prev_a    = prev_a_q & ~sof;

  always_comb begin
    case (mode)
      3'b010:  hit = is_first & (eq_a | eq_b);
      3'b011:  hit = eq_a | eq_b;
      3'b100:  hit = is_second & prev_a & eq_b;
      3'b101:  hit = prev_a & eq_b;
      3'b110:  hit = is_first & masked_eq;
      3'b111:  hit = masked_eq;
      default: hit = 1'b0;
    endcase
  end

  wire set_now = rx_valid & hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      first_q    <= 1'b1;
      second_q   <= 1'b0;
      prev_a_q   <= 1'b0;
      match_flag <= 1'b0;
    end else begin
      if (rx_valid) begin
        first_q  <= 1'b0;
        second_q <= is_first;
        prev_a_q <= eq_a;
      end else if (sof) begin
        first_q  <= 1'b1;
        second_q <= 1'b0;
        prev_a_q <= 1'b0;
      end
      match_flag <= set_now | (match_flag & ~flag_clr);
    end
  end

  assert_off_modes_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (mode[2:1] == 2'b00 && !match_flag) |=> !match_flag);

  assert_any_or_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && mode == 3'b011 && (rx_word == cmp_a || rx_word == cmp_b)) |=> match_flag);

  assert_masked_any_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && mode == 3'b111 && ((rx_word & cmp_b) == (cmp_a & cmp_b))) |=> match_flag);

  assert_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (match_flag && !flag_clr) |=> match_flag);

  assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !rx_valid) |=> !match_flag);

endmodule

// File: tb/spi_rx_match_tb_top.sv
module spi_rx_match_tb_top;
  localparam int W = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sof = 1'b0, rx_valid = 1'b0, flag_clr = 1'b0;
  logic [W-1:0] rx_word = '0, cmp_a = '0, cmp_b = '0;
  logic [2:0] mode = 3'b000;
  logic match_flag;

  int checks = 0, fails = 0;
  int m_idx = 0;
  bit m_prev_a = 1'b0;
  bit m_flag = 1'b0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  spi_rx_match #(.W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .sof(sof), .rx_valid(rx_valid),
    .rx_word(rx_word), .cmp_a(cmp_a), .cmp_b(cmp_b), .mode(mode),
    .flag_clr(flag_clr), .match_flag(match_flag)
  );

  function automatic string mode_tag(input logic [2:0] m);
    case (m)
      3'd0: return "R1"; 3'd1: return "R2"; 3'd2: return "R3"; 3'd3: return "R4";
      3'd4: return "R5"; 3'd5: return "R6"; 3'd6: return "R7"; default: return "R8";
    endcase
  endfunction

  function automatic bit model_hit(input bit s, input bit v, input logic [W-1:0] w,
                                   input logic [W-1:0] a, input logic [W-1:0] b,
                                   input logic [2:0] m, input int idx, input bit pa);
    bit opening = s || idx == 0;
    bit second  = !s && idx == 1;
    bit after_a = !s && pa;
    bit mk      = ((w & b) == (a & b));
    if (!v) return 1'b0;
    case (m)
      3'd2: return opening && (w == a || w == b);
      3'd3: return w == a || w == b;
      3'd4: return second && after_a && w == b;
      3'd5: return after_a && w == b;
      3'd6: return opening && mk;
      3'd7: return mk;
      default: return 1'b0;
    endcase
  endfunction

  task automatic check(input bit exp, input string tag);
    checks++;
    if (match_flag !== exp) begin
      fails++;
      $display("FAIL %s: match_flag=%0b expected=%0b at %0t", tag, match_flag, exp, $time);
    end
  endtask

  task automatic step(input bit s, input bit v, input logic [W-1:0] w,
                      input bit clr, input string tag);
    bit h;
    sof = s; rx_valid = v; rx_word = w; flag_clr = clr;
    h = model_hit(s, v, w, cmp_a, cmp_b, mode, m_idx, m_prev_a);
    m_flag = h || (m_flag && !clr);
    if (v) begin
      m_idx = (s || m_idx == 0) ? 1 : m_idx + 1;
      m_prev_a = (w == cmp_a);
    end else if (s) begin
      m_idx = 0;
      m_prev_a = 1'b0;
    end
    @(negedge clk);
    check(m_flag, tag);
  endtask

  task automatic clear_flag();
    step(1'b0, 1'b0, '0, 1'b1, "R9");
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd7021));
    repeat (3) @(negedge clk);
    check(1'b0, "R10");
    rst_n = 1'b1;
    cmp_a = 32'hCAFE_0001; cmp_b = 32'h0000_BEEF;

    mode = 3'b010;
    step(1'b0, 1'b1, cmp_b, 1'b0, "R10");
    check(1'b1, "R10");
    clear_flag();
    step(1'b0, 1'b1, cmp_a, 1'b0, "R3");
    check(1'b0, "R3");

    mode = 3'b001;
    step(1'b1, 1'b1, cmp_a, 1'b0, "R2");
    step(1'b0, 1'b1, cmp_b, 1'b0, "R2");
    check(1'b0, "R2");

    mode = 3'b100;
    step(1'b1, 1'b0, '0, 1'b0, "R5");
    step(1'b0, 1'b1, cmp_a, 1'b0, "R5");
    step(1'b0, 1'b1, cmp_b, 1'b0, "R5");
    check(1'b1, "R5");
    clear_flag();
    step(1'b1, 1'b1, 32'h1234, 1'b0, "R5");
    step(1'b0, 1'b1, cmp_a, 1'b0, "R5");
    step(1'b0, 1'b1, cmp_b, 1'b0, "R5");
    check(1'b0, "R5");

    mode = 3'b101;
    step(1'b1, 1'b1, 32'h1234, 1'b0, "R6");
    step(1'b0, 1'b1, cmp_a, 1'b0, "R6");
    step(1'b0, 1'b1, cmp_b, 1'b0, "R6");
    check(1'b1, "R6");
    clear_flag();
    step(1'b0, 1'b1, cmp_a, 1'b0, "R11");
    step(1'b1, 1'b1, cmp_b, 1'b0, "R11");
    check(1'b0, "R11");
    step(1'b0, 1'b1, cmp_a, 1'b0, "R6");
    step(1'b0, 1'b1, 32'h5555, 1'b0, "R6");
    step(1'b0, 1'b1, cmp_b, 1'b0, "R6");
    check(1'b0, "R6");

    mode = 3'b110;
    cmp_b = 32'hFFFF_0000;
    step(1'b1, 1'b1, 32'hCAFE_9999, 1'b0, "R7");
    check(1'b1, "R7");
    step(1'b0, 1'b1, 32'hCAFE_9999, 1'b1, "R9");
    check(1'b0, "R9");

    mode = 3'b011;
    step(1'b0, 1'b1, cmp_a, 1'b1, "R9");
    check(1'b1, "R9");
    clear_flag();

    for (int n = 0; n < 4000; n++) begin
      logic [W-1:0] w;
      bit s, v, clr;
      if (n % 50 == 0) begin
        cmp_a = $urandom;
        cmp_b = $urandom & 32'hFFFF_F0F0;
        mode = 3'($urandom % 8);
      end
      case ($urandom % 5)
        0: w = cmp_a;
        1: w = cmp_b;
        2: w = (cmp_a & cmp_b) | (32'($urandom) & ~cmp_b);
        default: w = $urandom;
      endcase
      s = ($urandom % 6) == 0;
      v = ($urandom % 3) != 0;
      clr = ($urandom % 6) == 0;
      step(s, v, w, clr, m_flag ? "R9" : mode_tag(mode));
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule